// File: doc/BRIEF.md
# Configurable Integer Min/Max Unit

This block is a purely combinational ALU slice. It takes two XLEN-bit operands (64 by default) and returns the smaller or the larger of the two. A 3-bit mode field selects how they are compared: as signed or unsigned values, and across the full width or across the low half only. One unsigned magnitude comparator serves every mode. Before comparing, each operand is reshaped: in word mode its low half is moved into the high half and the vacated bits are zero-filled, and in signed mode the top bit is inverted. Max mode is done by swapping which operand the less-than test favours.

The value written out is always the complete, untransformed source register, even when only the low halves were compared. The first operand can be forced to zero, as a zero register index would do. When the record input is set, a 4-bit condition field is also produced. It reports whether the reshaped first operand is below, above or equal to the reshaped second operand, followed by the incoming summary-overflow bit. A write-enable strobe for that field follows the record input.

There is no clock and there are no states. The house naming and layout are kept, but the datapath is a straight chain: operand reshaping, then the comparator, then the result pick.

Top module: `minmax_alu`

## Requirements
- R1: Mode bit 2 selects word mode, bit 1 selects signed compare and bit 0 selects max rather than min. Mode value 0 is unsigned min, 1 is unsigned max, 2 is signed min and 3 is signed max.
- R2: In min mode, `result` equals the first operand when it orders strictly below the second operand, and equals the second operand otherwise (ties included).
- R3: In max mode, `result` equals the first operand when it orders strictly above the second operand, and equals the second operand otherwise (ties included).
- R4: In signed mode, the operands are ordered as two's-complement numbers. For example, a signed min of 1 and 0x8000_0000_0000_0000 gives 0x8000_0000_0000_0000.
- R5: In word mode, only the low XLEN/2 bits of each operand take part in the ordering, and the upper halves have no effect on which source is picked. The output is still the full-width original operand.
- R6: When `src_a_is_zero` is 1, the first operand is taken as zero for both the ordering and the output.
- R7: When `record_en` is 1, `cond[3:1]` is 3'b100 when the first operand is below the second, 3'b010 when it is above and 3'b001 when they are equal. The order used is that of the current signedness and width, and it does not depend on the max bit. `cond[0]` equals `sum_ovf_in`.
- R8: `cond_we` equals `record_en`, and `cond` is 4'b0000 whenever `record_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_is_zero | input | 1 | Forces the first operand to zero |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| mode | input | 3 | {word, signed, max} mode select |
| record_en | input | 1 | Request the condition field |
| sum_ovf_in | input | 1 | Summary-overflow bit copied into cond[0] |
| result | output | XLEN | Selected full-width source value |
| cond | output | 4 | {below, above, equal, summary overflow} |
| cond_we | output | 1 | Write strobe for cond |

## Verification
The assertions assume that the inputs hold known, settled values whenever they are evaluated. They also assume that the comparator sees keys from the same mode for both operands. The bench meets both conditions by changing every input together, once per cycle, half a period away from the edge at which it compares. Random operands are mixed with hand-chosen pairs that land on ties, on the sign boundary, on all-ones, and on upper halves that differ while the low halves decide the outcome.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    typedef struct packed {
        logic word;
        logic sgn;
        logic take_max;
    } mmu_mode_t;

    function automatic mmu_mode_t mmu_decode(input logic [2:0] m);
        mmu_mode_t d;
        d.word     = m[2];
        d.sgn      = m[1];
        d.take_max = m[0];
        return d;
    endfunction
endpackage

// File: rtl/mmu_operand_prep.sv
module mmu_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  logic            word,
    input  logic            sgn,
    output logic [XLEN-1:0] key
);
    localparam int HALF = XLEN / 2;
    logic [XLEN-1:0] shaped;

    generate
        if (HALF > 0) begin : g_half
            always_comb begin
                if (word) shaped = {raw[HALF-1:0], {(XLEN-HALF){1'b0}}};
                else      shaped = raw;
            end
        end else begin : g_nohalf
            always_comb shaped = raw;
        end
    endgenerate

    always_comb begin
        key = shaped;
        key[XLEN-1] = shaped[XLEN-1] ^ sgn;
    end
endmodule

// File: rtl/mmu_order_cmp.sv
module mmu_order_cmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] key_a,
    input  logic [XLEN-1:0] key_b,
    output logic            below,
    output logic            above,
    output logic            same
);
    always_comb begin
        below = key_a < key_b;
        above = key_b < key_a;
        same  = key_a == key_b;
    end

    always_comb begin
        a_r7_order_exclusive: assert ($onehot({below, above, same}));
    end
endmodule

// File: rtl/mmu_result_pick.sv
module mmu_result_pick #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val_a,
    input  logic [XLEN-1:0] val_b,
    input  logic            below,
    input  logic            above,
    input  logic            take_max,
    output logic [XLEN-1:0] picked
);
    logic pick_a;
    always_comb begin
        pick_a = take_max ? above : below;
        picked = pick_a ? val_a : val_b;
    end
endmodule

// File: rtl/minmax_alu.sv
module minmax_alu
    import mmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            src_a_is_zero,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [2:0]      mode,
    input  logic            record_en,
    input  logic            sum_ovf_in,
    output logic [XLEN-1:0] result,
    output logic [3:0]      cond,
    output logic            cond_we
);
    mmu_mode_t       md;
    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] key_a, key_b;
    logic            below, above, same;

    always_comb begin
        md    = mmu_decode(mode);
        a_eff = src_a_is_zero ? '0 : src_a;
    end

    mmu_operand_prep #(.XLEN(XLEN)) u_prep_a (
        .raw(a_eff), .word(md.word), .sgn(md.sgn), .key(key_a));
    mmu_operand_prep #(.XLEN(XLEN)) u_prep_b (
        .raw(src_b), .word(md.word), .sgn(md.sgn), .key(key_b));

    mmu_order_cmp #(.XLEN(XLEN)) u_cmp (
        .key_a(key_a), .key_b(key_b),
        .below(below), .above(above), .same(same));

    mmu_result_pick #(.XLEN(XLEN)) u_pick (
        .val_a(a_eff), .val_b(src_b), .below(below), .above(above),
        .take_max(md.take_max), .picked(result));

    always_comb begin
        cond_we = record_en;
        cond    = record_en ? {below, above, same, sum_ovf_in} : 4'b0000;
    end

    always_comb begin
        a_r8_we_follows_record: assert (cond_we == record_en);
        if (!record_en) begin
            a_r8_cond_quiet: assert (cond == 4'b0000);
        end else begin
            a_r7_cond_shape: assert ($onehot(cond[3:1]) && (cond[0] == sum_ovf_in));
        end
        a_r2_source_only: assert ((result == src_b) || (result == a_eff));
        if (src_a_is_zero) begin
            a_r6_zero_first: assert ((result == src_b) || (result == '0));
        end
    end
endmodule

// File: tb/tb_minmax_alu.sv
module tb_minmax_alu;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            src_a_is_zero;
    logic [XLEN-1:0] src_a, src_b;
    logic [2:0]      mode;
    logic            record_en, sum_ovf_in;
    logic [XLEN-1:0] result;
    logic [3:0]      cond;
    logic            cond_we;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    minmax_alu #(.XLEN(XLEN)) dut (
        .src_a_is_zero(src_a_is_zero), .src_a(src_a), .src_b(src_b),
        .mode(mode), .record_en(record_en), .sum_ovf_in(sum_ovf_in),
        .result(result), .cond(cond), .cond_we(cond_we));

    task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic void model(input bit z, input logic [63:0] a, input logic [63:0] b,
                                  input logic [2:0] m, input bit rec, input bit so,
                                  output logic [63:0] r, output logic [3:0] c);
        logic [63:0] ea;
        logic signed [64:0] x, y;
        bit lt, gt, eq;
        ea = z ? 64'd0 : a;
        if (m[2]) begin
            if (m[1]) begin
                x = {{33{ea[31]}}, ea[31:0]};
                y = {{33{b[31]}}, b[31:0]};
            end else begin
                x = {33'd0, ea[31:0]};
                y = {33'd0, b[31:0]};
            end
        end else begin
            x = m[1] ? {ea[63], ea} : {1'b0, ea};
            y = m[1] ? {b[63], b}   : {1'b0, b};
        end
        lt = x < y; gt = x > y; eq = x == y;
        if (m[0]) r = gt ? ea : b;
        else      r = lt ? ea : b;
        c = rec ? {lt, gt, eq, so} : 4'd0;
    endfunction

    task automatic apply(input string tag, input bit z, input logic [63:0] a,
                         input logic [63:0] b, input logic [2:0] m,
                         input bit rec, input bit so);
        logic [63:0] er;
        logic [3:0]  ec;
        @(negedge clk);
        src_a_is_zero = z; src_a = a; src_b = b; mode = m;
        record_en = rec; sum_ovf_in = so;
        model(z, a, b, m, rec, so, er, ec);
        @(posedge clk);
        #1;
        chk({tag, " result"}, result, er);
        chk({tag, " cond R7"}, {60'd0, cond}, {60'd0, ec});
        chk({tag, " we R8"}, {63'd0, cond_we}, {63'd0, rec});
    endtask

    initial begin
        src_a_is_zero = 0; src_a = 0; src_b = 0; mode = 0;
        record_en = 0; sum_ovf_in = 0;
        @(posedge clk); #1;
        chk("reset-idle R8", {60'd0, cond}, 64'd0);

        // R4 / R1 signed min vs unsigned min examples
        apply("R4 smin", 0, 64'd1, 64'h8000_0000_0000_0000, 3'd2, 1, 0);
        chk("R4 smin val", result, 64'h8000_0000_0000_0000);
        chk("R4 smin cc", {60'd0, cond}, 64'h4);
        apply("R1 umin", 0, 64'd1, 64'h8000_0000_0000_0000, 3'd0, 1, 0);
        chk("R1 umin val", result, 64'd1);
        chk("R1 umin cc", {60'd0, cond}, 64'h8);
        // ties R2 R3
        apply("R2 tie", 0, 64'h55, 64'h55, 3'd0, 1, 1);
        apply("R3 tie", 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 1, 0);
        apply("R3 ones", 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 3'd3, 1, 0);
        apply("R3 umax ones", 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 3'd1, 1, 0);
        // R5 word mode: upper halves differ, low halves decide
        apply("R5 word umin", 0, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_0000_0001, 3'd4, 1, 0);
        chk("R5 word full", result, 64'hFFFF_FFFF_0000_0001);
        apply("R5 word smax", 0, 64'h1234_0000_8000_0000, 64'hABCD_0000_0000_0001, 3'd7, 1, 0);
        apply("R5 word eq", 0, 64'h1111_1111_0000_0009, 64'h2222_2222_0000_0009, 3'd6, 1, 1);
        // R6 zero substitution
        apply("R6 zero", 1, 64'h7777, 64'h5, 3'd0, 1, 0);
        chk("R6 zero val", result, 64'd0);
        // R8 record off
        apply("R8 norec", 0, 64'd3, 64'd4, 3'd1, 0, 1);

        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 40; k++) begin
                logic [63:0] ra, rb;
                ra = {$urandom, $urandom};
                rb = (k % 5 == 0) ? ra : {$urandom, $urandom};
                if (k % 7 == 0) rb[31:0] = ra[31:0];
                apply(m[2] ? "R5 rnd" : (m[1] ? "R4 rnd" : (m[0] ? "R3 rnd" : "R2 rnd")),
                      (k % 11 == 3), ra, rb, 3'(m), ($urandom % 2) == 1, ($urandom % 2) == 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog R1 got=%0d exp=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule